// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

This block is a purely combinational 32-bit shifter. It takes its shift count from the lowest byte of a general register. It returns the shifted word together with the shifter carry flag.

Four shift kinds are selected by a 2-bit code:

- logical left
- logical right
- arithmetic right
- rotate right

The carry flag follows fixed rules at the edges of the count range: a count of zero, a count of exactly the word width, a count beyond it, and rotations by a nonzero multiple of the width. The result and the carry are valid in the same cycle as the inputs. The block holds no state and has no clock.

There is no flow-control handshake. An execute stage places the block between its operand read and its writeback or flag register. When that stage stalls, it simply holds the inputs.

Top module: `reg_shifter`

## Requirements
- R1: Only bits [7:0] of `amt_reg` set the count n (0..255). Changing bits [31:8] never changes `result_out` or `carry_out`.
- R2: When n is 0, for every shift kind, `result_out` equals `op_in` and `carry_out` equals `carry_in`.
- R3: For shift kind 0 (logical left) with n from 1 to 31, the result is `op_in` shifted left by n with zeros filled in, and the carry is `op_in[32-n]`.
- R4: For shift kind 0 with n equal to 32, the result is zero and the carry is `op_in[0]`. With n above 32, both the result and the carry are zero.
- R5: For shift kind 1 (logical right) with n from 1 to 31, the result is `op_in` shifted right by n with zeros filled in, and the carry is `op_in[n-1]`.
- R6: For shift kind 1 with n equal to 32, the result is zero and the carry is `op_in[31]`. With n above 32, both the result and the carry are zero.
- R7: For shift kind 2 (arithmetic right) with n from 1 to 31, the result is shifted right with copies of `op_in[31]` filled in, and the carry is `op_in[n-1]`. With n of 32 or more, every result bit equals `op_in[31]` and the carry is `op_in[31]`.
- R8: For shift kind 3 (rotate right), m is n modulo 32. When m is nonzero, the result is `op_in` rotated right by m and the carry is `op_in[m-1]`.
- R9: For shift kind 3 with n nonzero and m zero (n = 32, 64, ..., 224), the result equals `op_in` and the carry is `op_in[31]`.
- R10: The outputs depend only on the present inputs, with no register stage. A new input set is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_in | input | 32 | Operand word to shift |
| amt_reg | input | 32 | Register holding the shift count; only bits [7:0] are used |
| shift_kind | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| carry_in | input | 1 | Current carry flag, passed through when the count is zero |
| result_out | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | Shifter carry flag |

## Verification
Uniform random counts rarely land on the cases that matter: a rotation by an exact nonzero multiple of 32, counts of exactly 32 and 33, and counts whose upper register bits are set. Uniform draws hit the multiples of 32 on only seven of 256 values, so the stimulus forces them. A directed set walks every one of those boundary counts for every shift kind, with random upper register bits and both carry-in values. A random phase then draws each count from a mix of boundary values and a full-range byte. Every cycle is compared against a behavioural bit-loop model.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amt,
  output logic             is_zero,
  output logic             is_full,
  output logic             is_over,
  output logic [LOG_W-1:0] low,
  output logic             low_zero
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

  always_comb begin
    is_zero  = (amt == '0);
    is_full  = (amt == FULL);
    is_over  = (amt > FULL);
    low      = amt[LOG_W-1:0];
    low_zero = (amt[LOG_W-1:0] == '0);
  end
endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [LOG_W-1:0] k,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [0:LOG_W];

  assign stg[0] = din;

  for (genvar s = 0; s < LOG_W; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = k[s] ? {stg[s][D-1:0], stg[s][WIDTH-1:D]} : stg[s];
  end

  assign dout = stg[LOG_W];
endmodule

// File: rtl/shf_carry_select.sv
module shf_carry_select
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] op,
  input  shift_kind_e      kind,
  input  logic             cin,
  input  logic             is_zero,
  input  logic             is_full,
  input  logic             is_over,
  input  logic             low_zero,
  input  logic [LOG_W-1:0] low,
  input  logic [LOG_W-1:0] left_k,
  output logic             cout
);
  logic [LOG_W-1:0] idx_right;
  assign idx_right = low - 1'b1;

  always_comb begin
    cout = 1'b0;
    if (is_zero) begin
      cout = cin;
    end else begin
      unique case (kind)
        SK_LSL: cout = is_over ? 1'b0 : (is_full ? op[0] : op[left_k]);
        SK_LSR: cout = is_over ? 1'b0 : (is_full ? op[WIDTH-1] : op[idx_right]);
        SK_ASR: cout = (is_over || is_full) ? op[WIDTH-1] : op[idx_right];
        SK_ROR: cout = low_zero ? op[WIDTH-1] : op[idx_right];
        default: cout = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/reg_shifter.sv
module reg_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] op_in,
  input  logic [REG_W-1:0] amt_reg,
  input  logic [1:0]       shift_kind,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result_out,
  output logic             carry_out
);
  logic [AMT_W-1:0] amt;
  logic             amt_unused_hi;
  logic             is_zero, is_full, is_over, low_zero;
  logic [LOG_W-1:0] low, left_k, rot_k;
  logic [WIDTH-1:0] rot, mask_lo, mask_hi, sign_fill;
  shift_kind_e      kind;

  assign amt           = amt_reg[AMT_W-1:0];
  assign amt_unused_hi = ^amt_reg[REG_W-1:AMT_W];
  assign kind          = shift_kind_e'(shift_kind);

  shf_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
    .amt(amt), .is_zero(is_zero), .is_full(is_full), .is_over(is_over),
    .low(low), .low_zero(low_zero)
  );

  // a left shift by n is a right rotation by (WIDTH - n) mod WIDTH
  assign left_k = '0 - low;
  assign rot_k  = (kind == SK_LSL) ? left_k : low;

  shf_rotator #(.WIDTH(WIDTH)) u_rot (
    .din(op_in), .k(rot_k), .dout(rot)
  );

  assign mask_lo   = {WIDTH{1'b1}} >> low;
  assign mask_hi   = {WIDTH{1'b1}} << low;
  assign sign_fill = {WIDTH{op_in[WIDTH-1]}};

  always_comb begin
    result_out = op_in;
    if (!is_zero) begin
      unique case (kind)
        SK_LSL: result_out = (is_full || is_over) ? '0 : (rot & mask_hi);
        SK_LSR: result_out = (is_full || is_over) ? '0 : (rot & mask_lo);
        SK_ASR: result_out = (is_full || is_over) ? sign_fill
                                                  : ((rot & mask_lo) | (sign_fill & ~mask_lo));
        SK_ROR: result_out = rot;
        default: result_out = op_in;
      endcase
    end
  end

  shf_carry_select #(.WIDTH(WIDTH)) u_cry (
    .op(op_in), .kind(kind), .cin(carry_in), .is_zero(is_zero),
    .is_full(is_full), .is_over(is_over), .low_zero(low_zero),
    .low(low), .left_k(left_k), .cout(carry_out)
  );
endmodule

// File: rtl/reg_shifter_checker.sv
module reg_shifter_checker #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] op_in,
  input logic [AMT_W-1:0] amt_lo,
  input logic [1:0]       shift_kind,
  input logic             carry_in,
  input logic [WIDTH-1:0] result_out,
  input logic             carry_out
);
  int unsigned n;
  assign n = 32'(amt_lo);

  always_comb begin
    // R2
    zero_amt_chk: assert (n != 0 || (result_out == op_in && carry_out == carry_in));
    // R4
    lsl_over_chk: assert (!(shift_kind == 2'd0 && n > WIDTH) || (result_out == '0 && carry_out == 1'b0));
    // R6
    lsr_full_chk: assert (!(shift_kind == 2'd1 && n == WIDTH) || (result_out == '0 && carry_out == op_in[WIDTH-1]));
    // R7
    asr_fill_chk: assert (!(shift_kind == 2'd2 && n >= WIDTH) ||
                          (result_out == {WIDTH{op_in[WIDTH-1]}} && carry_out == op_in[WIDTH-1]));
    // R8
    ror_bits_chk: assert (shift_kind != 2'd3 || $countones(result_out) == $countones(op_in));
    // R9
    ror_mult_chk: assert (!(shift_kind == 2'd3 && n != 0 && amt_lo[LOG_W-1:0] == '0) ||
                          (result_out == op_in && carry_out == op_in[WIDTH-1]));
  end
endmodule

bind reg_shifter reg_shifter_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .op_in(op_in), .amt_lo(amt_reg[AMT_W-1:0]), .shift_kind(shift_kind),
  .carry_in(carry_in), .result_out(result_out), .carry_out(carry_out)
);

// File: tb/reg_shifter_test.sv
module reg_shifter_test;
  logic        clk = 1'b0;
  logic [31:0] op_in = '0, amt_reg = '0;
  logic [1:0]  shift_kind = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result_out;
  logic        carry_out;
  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reg_shifter uut (
    .op_in(op_in), .amt_reg(amt_reg), .shift_kind(shift_kind),
    .carry_in(carry_in), .result_out(result_out), .carry_out(carry_out)
  );

  function automatic void model(input logic [31:0] op, input logic [31:0] ar,
                                input int t, input logic c,
                                output logic [31:0] r, output logic rc);
    int n;
    int m;
    n = int'(ar[7:0]);
    r = op; rc = c;
    if (n == 0) return;
    case (t)
      0: begin
        for (int i = 0; i < 32; i++) r[i] = (i - n >= 0) ? op[i-n] : 1'b0;
        rc = (n <= 32) ? op[32-n] : 1'b0;
      end
      1: begin
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : 1'b0;
        rc = (n <= 32) ? op[n-1] : 1'b0;
      end
      2: begin
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? op[i+n] : op[31];
        rc = (n >= 32) ? op[31] : op[n-1];
      end
      default: begin
        m = n % 32;
        for (int i = 0; i < 32; i++) r[i] = op[(i+m)%32];
        rc = (m == 0) ? op[31] : op[m-1];
      end
    endcase
  endfunction

  task automatic apply(input logic [31:0] op, input logic [31:0] ar, input int t,
                       input logic c, input string tag);
    logic [31:0] er;
    logic ec;
    @(posedge clk); #1;
    op_in = op; amt_reg = ar; shift_kind = 2'(t); carry_in = c;
    model(op, ar, t, c, er, ec);
    @(negedge clk);
    total++;
    if (result_out !== er || carry_out !== ec) begin
      bad++;
      $display("FAIL %s: kind=%0d amt=%0d op=%h got res=%h c=%b exp res=%h c=%b",
               tag, t, ar[7:0], op, result_out, carry_out, er, ec);
    end
  endtask

  function automatic string tag_for(input int t, input int n);
    if (n == 0) return "R2";
    case (t)
      0: return (n < 32) ? "R3" : "R4";
      1: return (n < 32) ? "R5" : "R6";
      2: return "R7";
      default: return (n % 32 == 0) ? "R9" : "R8";
    endcase
  endfunction

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expired at %0d cycles, expected completion", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int edges[12] = '{0, 1, 2, 31, 32, 33, 63, 64, 96, 128, 224, 255};
    int n;
    // R10 first vector settles in the same cycle it is driven
    apply(32'h8000_0001, 32'h0000_0001, 0, 1'b0, "R10");
    // R2 zero count keeps operand and carry
    for (int t = 0; t < 4; t++) begin
      apply(32'hDEAD_BEEF, 32'hFFFF_FF00, t, 1'b1, "R2");
      apply(32'h1234_5678, 32'h0000_0000, t, 1'b0, "R2");
    end
    // R3 R4 R5 R6 R7 R8 R9 boundary walk
    for (int t = 0; t < 4; t++)
      for (int e = 0; e < 12; e++)
        for (int c = 0; c < 2; c++) begin
          apply(32'hA5C3_0F81, {$urandom() & 32'hFFFF_FF00} | 32'(edges[e]), t, c[0],
                tag_for(t, edges[e]));
          apply(32'h7F00_00FE, 32'(edges[e]), t, c[0], tag_for(t, edges[e]));
        end
    // R9 every multiple of 32 with garbage upper bits
    for (int k = 1; k < 8; k++) begin
      apply(32'h8000_0000 | $urandom(), ($urandom() << 8) | 32'(k * 32), 3, 1'b0, "R9");
      apply(32'h0000_0001, 32'(k * 32), 3, 1'b1, "R9");
    end
    // R1 upper register bits ignored: same low byte, different upper bits
    for (int i = 0; i < 16; i++) begin
      n = int'($urandom() % 256);
      apply(32'hC001_D00D, 32'(n), i % 4, 1'b1, "R1");
      apply(32'hC001_D00D, ($urandom() << 8) | 32'(n), i % 4, 1'b1, "R1");
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int t;
      t = int'($urandom() % 4);
      n = ($urandom() % 2 == 0) ? edges[$urandom() % 12] : int'($urandom() % 256);
      apply($urandom(), ($urandom() << 8) | 32'(n), t, 1'($urandom()), tag_for(t, n));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule